// File: doc/BRIEF.md
# Stop-Triggered Circular Capture Buffer

The block keeps a rolling record of a stream of 16-bit data words. While it is armed, every word that arrives with its valid strobe goes into a 2048-entry ring memory. The write address wraps at the end of the ring, so the memory always holds the most recent 2048 words.

An asynchronous stop pulse ends recording. The block passes the stop through two synchronising flops and acts on its rising edge. From then on the ring is frozen and a ready flag tells the host that a capture is waiting. The host reads a count register, then drains the words oldest-first through an auto-incrementing data register. It re-arms the buffer by writing 1 to the arm bit of the control register.

The host side is a plain register port. A read pulse returns data on `reg_rdata` one cycle later. A write pulse takes effect at the clock edge that samples it.

Top module: `stop_capture_buffer`

## Requirements
- R1: After reset the buffer is armed and nothing is captured. A read of the control/status register (address 0) returns bit0 ready=0, bit1 wrapped=0 and bit2 armed=1, which is 16'h0004. The count register (address 1) returns 0.
- R2: While armed, each word with `din_valid` high is stored at the write pointer, and the pointer then advances modulo 2048. Once 2048 words have been stored, status bit1 (wrapped) is 1, and only the latest 2048 words remain.
- R3: Once the buffer is frozen, no incoming word is stored. The count and the captured data stay unchanged whatever arrives on `din`.
- R4: Suppose `stop_in` is high at clock edge k. Words sampled at edges k and k+1 are still stored. At edge k+2 the buffer freezes, and status reads ready=1 and armed=0 (value 16'h0001 or 16'h0003).
- R5: Only a rising edge of `stop_in` freezes the buffer. A stop that stays high, and any stop edge while the buffer is already frozen, have no effect.
- R6: When the buffer freezes, the readout pointer is placed at the oldest word: the write pointer if the ring has wrapped, else address 0. The count register reads 2048 if the ring has wrapped, else the number of words stored.
- R7: Each read of the data register (address 2) returns the word at the readout pointer on `reg_rdata` in the cycle after `reg_rd`. The pointer then advances modulo 2048, so successive reads give the capture oldest-first, and read 2049 of a full ring returns the oldest word again.
- R8: A write to address 0 with bit0=1 clears ready and wrapped, zeroes both pointers and the count, and resumes capture. The word present in that cycle is not stored. A write to address 0 with bit0=0 changes nothing.
- R9: A valid word in the cycle where the synchronised stop edge is seen (edge k+2 in R4) is not stored.
- R10: When an arm write and the synchronised stop edge fall in the same cycle, the arm wins, the stop edge is discarded, and the buffer stays armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 16 | Incoming data word |
| din_valid | input | 1 | Qualifies `din` in this cycle |
| stop_in | input | 1 | Asynchronous stop request, acted on at its rising edge |
| reg_addr | input | 2 | Register select: 0 control/status, 1 count, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data (bit0 = arm) |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |

## Verification
Two pairs of functions can fall in the same cycle. The first is a valid incoming word with the synchronised stop edge. The bench keeps `din_valid` high while it raises `stop_in` under a known word, then counts the stored words and checks the last one: the two words after the stop must be kept and the third dropped. The second is a host arm write with the stop edge. The bench times the arm write two cycles after raising `stop_in`, then judges by the status register that the buffer is still armed and that a stop held high does not freeze it later.

// File: rtl/cap_pkg.sv
// Package: register selects and status bit positions of the capture buffer.
// Assumes a 2-bit register address on the host port.
package cap_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_DATA  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    localparam int STAT_READY   = 0;
    localparam int STAT_WRAPPED = 1;
    localparam int STAT_ARMED   = 2;
    localparam int ARM_BIT      = 0;
endpackage

// File: rtl/stop_sync.sv
// stop_sync: two-flop synchroniser for the asynchronous stop, plus a
// rising-edge detector. Assumes stop pulses last at least one clock period.
module stop_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_async,
    output logic stop_edge
);
    logic meta_q, sync_q, hist_q;

    // Resynchronise the stop and keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            hist_q <= 1'b0;
        end else begin
            meta_q <= stop_async;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign stop_edge = sync_q & ~hist_q;

    // A held stop yields a single-cycle edge (R5).
    assert_single_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_edge |=> !stop_edge);
endmodule

// File: rtl/ring_store.sv
// ring_store: simple dual-port ring memory with a registered read port.
// Assumes DEPTH is a power of two; writes and reads use independent addresses.
module ring_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2048,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] cells [DEPTH];

    // Store an accepted word.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Fetch the word at the readout pointer on a data-register read.
    always_ff @(posedge clk) begin
        if (re) q <= cells[raddr];
    end
endmodule

// File: rtl/ring_ctrl.sv
// ring_ctrl: write/read pointers, wrapped flag, armed/ready state.
// Assumes arm requests and stop edges are single-cycle pulses; arm has priority.
module ring_ctrl #(
    parameter int DEPTH = 2048,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din_valid,
    input  logic              stop_edge,
    input  logic              arm_req,
    input  logic              data_rd,
    output logic              mem_we,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic              armed,
    output logic              ready,
    output logic              wrapped,
    output logic [CNT_W-1:0]  count
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic freeze;
    assign freeze = armed & stop_edge & ~arm_req;
    assign mem_we = din_valid & armed & ~stop_edge & ~arm_req;
    assign count  = wrapped ? CNT_W'(DEPTH) : {1'b0, wr_ptr};

    // Pointer and state update: arm, then freeze, then normal write/read.
    always_ff @(posedge clk) begin
        if (!rst_n || arm_req) begin
            armed   <= 1'b1;
            ready   <= 1'b0;
            wrapped <= 1'b0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else if (freeze) begin
            armed  <= 1'b0;
            ready  <= 1'b1;
            rd_ptr <= wrapped ? wr_ptr : '0;
        end else begin
            if (mem_we) begin
                wr_ptr <= wr_ptr + 1'b1;
                if (wr_ptr == LAST) wrapped <= 1'b1;
            end
            if (data_rd) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !arm_req) |=> ($stable(wr_ptr) && !mem_we));
    assert_ready_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && stop_edge && !arm_req) |=> (ready && !armed));
    assert_wrap_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wrapped && !arm_req) |=> wrapped);
    assert_rd_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !arm_req && !(armed && stop_edge)) |=> rd_ptr == $past(rd_ptr) + 1'b1);
    assert_arm_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arm_req |=> (armed && !ready && !wrapped && wr_ptr == '0));
    assert_arm_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_req && stop_edge) |=> !ready);
    assert_state_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({armed, ready}));
endmodule

// File: rtl/stop_capture_buffer.sv
// stop_capture_buffer: ring capture of a word stream, frozen by an
// asynchronous stop, drained oldest-first through a register port.
// Assumes DEPTH is a power of two and DATA_W can hold the count.
module stop_capture_buffer #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2048,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              din_valid,
    input  logic              stop_in,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata
);
    import cap_pkg::*;

    logic              stop_edge, arm_req, data_rd, mem_we;
    logic              armed, ready, wrapped;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] mem_q, info_q, status;
    logic              data_sel_q;
    logic              unused_wbits;

    assign arm_req      = reg_wr && (reg_addr == SEL_CTRL) && reg_wdata[ARM_BIT];
    assign data_rd      = reg_rd && (reg_addr == SEL_DATA);
    assign unused_wbits = ^reg_wdata[DATA_W-1:1];

    always_comb begin
        status               = '0;
        status[STAT_READY]   = ready;
        status[STAT_WRAPPED] = wrapped;
        status[STAT_ARMED]   = armed;
    end

    stop_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_async (stop_in),
        .stop_edge  (stop_edge)
    );

    ring_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .din_valid (din_valid),
        .stop_edge (stop_edge),
        .arm_req   (arm_req),
        .data_rd   (data_rd),
        .mem_we    (mem_we),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .armed     (armed),
        .ready     (ready),
        .wrapped   (wrapped),
        .count     (count)
    );

    ring_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_ptr),
        .wdata (din),
        .re    (data_rd),
        .raddr (rd_ptr),
        .q     (mem_q)
    );

    // Register the read selection and the status/count snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_sel_q <= 1'b0;
            info_q     <= '0;
        end else if (reg_rd) begin
            data_sel_q <= (reg_addr == SEL_DATA);
            case (reg_addr)
                SEL_CTRL:  info_q <= status;
                SEL_COUNT: info_q <= DATA_W'(count);
                default:   info_q <= '0;
            endcase
        end
    end

    assign reg_rdata = data_sel_q ? mem_q : info_q;

    // A word is never stored in the cycle where the stop edge is seen.
    assert_drop_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_edge |-> !mem_we);
    // A stop edge on a frozen buffer leaves the ready flag in place.
    assert_ignore_late_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && stop_edge && !arm_req) |=> ready);
endmodule

// File: tb/test_stop_capture_buffer.sv
module test_stop_capture_buffer;
    localparam int DEPTH = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] din = '0;
    logic        din_valid = 1'b0;
    logic        stop_in = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_rdata;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    stop_capture_buffer i_stop_capture_buffer (
        .clk(clk), .rst_n(rst_n), .din(din), .din_valid(din_valid),
        .stop_in(stop_in), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    // Capture vectors: {number of words pushed, first word value}.
    localparam logic [31:0] VEC [5] = '{
        {16'd5,    16'h1000},
        {16'd2048, 16'h2000},
        {16'd2049, 16'h3000},
        {16'd3000, 16'h4000},
        {16'd1,    16'hA000}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic push(input int n, input logic [15:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            din = base + 16'(i); din_valid = 1'b1;
        end
        @(negedge clk);
        din_valid = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_in = 1'b1;
        repeat (3) @(negedge clk);
        stop_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        host_read(2'd0, v); check("R1 status", v, 16'h0004);
        host_read(2'd1, v); check("R1 count", v, 16'h0000);

        // Vector table: R2, R4, R6, R7
        for (int t = 0; t < 5; t++) begin
            int n; logic [15:0] base, first; int cnt;
            n = int'(VEC[t][31:16]); base = VEC[t][15:0];
            host_write(2'd0, 16'h0001);
            push(n, base);
            pulse_stop();
            cnt   = (n > DEPTH) ? DEPTH : n;
            first = base + 16'((n > DEPTH) ? n - DEPTH : 0);
            host_read(2'd0, v);
            check("R4/R2 status ready+wrapped", v, (n >= DEPTH) ? 16'h0003 : 16'h0001);
            host_read(2'd1, v); check("R6 count", v, 16'(cnt));
            for (int i = 0; i < cnt; i++) begin
                host_read(2'd2, v);
                check("R7 oldest-first data", v, first + 16'(i));
            end
            if (n >= DEPTH) begin
                host_read(2'd2, v); check("R7 pointer wraps to oldest", v, first);
            end
        end

        // R3/R5: frozen buffer ignores words and further stop edges
        push(4, 16'hBEEF);
        pulse_stop();
        host_read(2'd0, v); check("R5 still ready after late stop", v, 16'h0001);
        host_read(2'd1, v); check("R3 count unchanged", v, 16'h0001);

        // R8: writing 0 to control does nothing; arm clears
        host_write(2'd0, 16'h0000);
        host_read(2'd0, v); check("R8 zero write ignored", v, 16'h0001);
        host_write(2'd0, 16'h0001);
        host_read(2'd0, v); check("R8 armed after arm", v, 16'h0004);
        host_read(2'd1, v); check("R8 count cleared", v, 16'h0000);

        // R9/R4: stream through the stop; words at edges k, k+1 kept, k+2 dropped
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            din = 16'h5500 + 16'(i); din_valid = 1'b1;
            if (i == 10) stop_in = 1'b1;
        end
        @(negedge clk); din_valid = 1'b0;
        repeat (2) @(negedge clk);
        host_read(2'd1, v); check("R9 count excludes word at stop edge", v, 16'd12);
        for (int i = 0; i < 11; i++) host_read(2'd2, v);
        host_read(2'd2, v); check("R4 last kept word", v, 16'h550B);
        // R5: stop still held high; re-arm then no trigger from the level
        host_write(2'd0, 16'h0001);
        push(2, 16'h6600);
        host_read(2'd0, v); check("R5 held stop does not freeze", v, 16'h0004);
        host_read(2'd1, v); check("R5 words stored under held stop", v, 16'd2);
        stop_in = 1'b0;
        repeat (3) @(negedge clk);

        // R10: arm write in the same cycle as the synchronised stop edge
        host_write(2'd0, 16'h0001);
        @(negedge clk); stop_in = 1'b1;
        @(negedge clk);
        host_write(2'd0, 16'h0001);
        repeat (2) @(negedge clk);
        host_read(2'd0, v); check("R10 arm wins over stop", v, 16'h0004);
        push(3, 16'h7700);
        host_read(2'd1, v); check("R10 capture continues", v, 16'd3);
        stop_in = 1'b0;
        pulse_stop();
        host_read(2'd0, v); check("R4 fresh edge freezes", v, 16'h0001);
        host_read(2'd2, v); check("R6 unwrapped readout starts at 0", v, 16'h7700);

        finish_run();
    end
endmodule